// File: doc/BRIEF.md
# Data-Capture Reservation Station

This block is one partition of a distributed issue queue that feeds a single class of functional unit. Each dispatched instruction brings two source operands. An operand arrives either as a finished value or as the rename tag of a result that does not exist yet. The station keeps the operand values in its own entries. It watches the result broadcast bus, and when a broadcast tag matches a pending operand it copies the broadcast value into that entry.

In every cycle the station picks one entry whose operands are both present. It presents that entry on the issue port together with its opcode, destination tag and both operand values. The entry is released at the same clock edge, so the functional unit receives values straight from the station and never stalls. Operand read, renaming and execution happen outside this block.

Top module: `rs_capture_station`

## Requirements
- R1: After reset no entry is occupied, `iss_valid` is 0 and `disp_full` is 0.
- R2: An instruction dispatched with both operands marked ready is presented on the issue port in the next cycle, with its opcode, destination tag and both operand values unchanged, provided no lower-index entry is also ready.
- R3: A pending operand carries its awaited tag in the low `TAG_W` bits of its value field. When `res_valid` is 1 and `res_tag` equals that tag, the entry stores `res_data` as the operand value at that clock edge and treats the operand as ready from the next cycle.
- R4: An entry is never issued while either of its operands is still pending.
- R5: If a dispatch and a matching broadcast occur in the same cycle, the arriving instruction takes the broadcast value for the matching operand.
- R6: At most one entry issues per cycle, and among the ready entries the one with the lowest index is chosen. A dispatch fills the lowest-index free entry.
- R7: The entry presented on the issue port is freed at the next clock edge, so `disp_full` drops in the cycle after an issue from a full station.
- R8: `disp_full` is 1 exactly when every entry is occupied. A dispatch offered while `disp_full` is 1 is dropped and leaves all entries unchanged.
- R9: A broadcast whose tag matches no pending operand changes no entry.
- R10: When `res_valid` is 0, `res_tag` and `res_data` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_dst | input | TAG_W | Destination rename tag |
| disp_a_rdy | input | 1 | Operand A is a value (1) or a pending tag (0) |
| disp_a | input | DATA_W | Operand A value, or awaited tag in the low TAG_W bits |
| disp_b_rdy | input | 1 | Operand B is a value (1) or a pending tag (0) |
| disp_b | input | DATA_W | Operand B value, or awaited tag in the low TAG_W bits |
| disp_full | output | 1 | No free entry remains |
| res_valid | input | 1 | Result broadcast valid |
| res_tag | input | TAG_W | Tag of the broadcast result |
| res_data | input | DATA_W | Value of the broadcast result |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_op | output | OP_W | Opcode of the issued instruction |
| iss_dst | output | TAG_W | Destination tag of the issued instruction |
| iss_a | output | DATA_W | Captured value of operand A |
| iss_b | output | DATA_W | Captured value of operand B |

## Verification
The bench uses the defaults: four entries, 4-bit tags, 16-bit data and 4-bit opcodes. With only four entries the station reaches the full state after four dispatches. Sixteen tags make random broadcasts hit pending operands often, and they also make several entries wait on the same tag, so one broadcast can wake more than one entry at once and exercise the lowest-index choice. Directed phases cover a dispatch and a capture in the same cycle, broadcasts that are invalid or carry a foreign tag, and a dispatch offered while full. A long random phase then checks issue order and captured values against the model in every cycle.

// File: rtl/rs_pkg.sv
package rs_pkg;
   localparam int RS_NSRC        = 2;
   localparam int RS_DEF_ENTRIES = 4;
   localparam int RS_DEF_TAG_W   = 4;
   localparam int RS_DEF_DATA_W  = 16;
   localparam int RS_DEF_OP_W    = 4;
endpackage

// File: rtl/rs_src_capture.sv
// Tag-match capture for one source operand: used on the dispatch path and in every entry.
module rs_src_capture #(
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic              in_rdy,
   input  logic [DATA_W-1:0] in_val,
   input  logic              res_valid,
   input  logic [TAG_W-1:0]  res_tag,
   input  logic [DATA_W-1:0] res_data,
   output logic              out_rdy,
   output logic [DATA_W-1:0] out_val
);
   logic hit;
   assign hit     = !in_rdy && res_valid && (in_val[TAG_W-1:0] == res_tag);
   assign out_rdy = in_rdy | hit;
   assign out_val = hit ? res_data : in_val;
endmodule

// File: rtl/rs_pick.sv
// Lowest-index priority picker, one-hot grant.
module rs_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   always_comb begin
      gnt = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) gnt = N'(1) << i;
      end
   end
   assign any = |req;
endmodule

// File: rtl/rs_entry.sv
// One station slot: holds opcode, destination and two captured operands.
module rs_entry
   import rs_pkg::*;
#(
   parameter int OP_W   = 4,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            alloc,
   input  logic [OP_W-1:0]                 alloc_op,
   input  logic [TAG_W-1:0]                alloc_dst,
   input  logic [RS_NSRC-1:0]              alloc_rdy,
   input  logic [RS_NSRC-1:0][DATA_W-1:0]  alloc_val,
   input  logic                            res_valid,
   input  logic [TAG_W-1:0]                res_tag,
   input  logic [DATA_W-1:0]               res_data,
   input  logic                            release_i,
   output logic                            valid,
   output logic                            ready,
   output logic [OP_W-1:0]                 op,
   output logic [TAG_W-1:0]                dst,
   output logic [RS_NSRC-1:0][DATA_W-1:0]  val
);
   logic [RS_NSRC-1:0]             rdy_q;
   logic [RS_NSRC-1:0]             wk_rdy;
   logic [RS_NSRC-1:0][DATA_W-1:0] wk_val;

   for (genvar s = 0; s < RS_NSRC; s++) begin : g_src
      rs_src_capture #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_cap (
         .in_rdy   (rdy_q[s]),
         .in_val   (val[s]),
         .res_valid(res_valid),
         .res_tag  (res_tag),
         .res_data (res_data),
         .out_rdy  (wk_rdy[s]),
         .out_val  (wk_val[s])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         rdy_q <= '0;
         op    <= '0;
         dst   <= '0;
         val   <= '0;
      end else if (alloc) begin
         valid <= 1'b1;
         rdy_q <= alloc_rdy;
         op    <= alloc_op;
         dst   <= alloc_dst;
         val   <= alloc_val;
      end else begin
         if (release_i) valid <= 1'b0;
         rdy_q <= wk_rdy;
         val   <= wk_val;
      end
   end

   assign ready = valid && (&rdy_q);
endmodule

// File: rtl/rs_capture_station.sv
module rs_capture_station
   import rs_pkg::*;
#(
   parameter int ENTRIES = RS_DEF_ENTRIES,
   parameter int TAG_W   = RS_DEF_TAG_W,
   parameter int DATA_W  = RS_DEF_DATA_W,
   parameter int OP_W    = RS_DEF_OP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              disp_valid,
   input  logic [OP_W-1:0]   disp_op,
   input  logic [TAG_W-1:0]  disp_dst,
   input  logic              disp_a_rdy,
   input  logic [DATA_W-1:0] disp_a,
   input  logic              disp_b_rdy,
   input  logic [DATA_W-1:0] disp_b,
   output logic              disp_full,
   input  logic              res_valid,
   input  logic [TAG_W-1:0]  res_tag,
   input  logic [DATA_W-1:0] res_data,
   output logic              iss_valid,
   output logic [OP_W-1:0]   iss_op,
   output logic [TAG_W-1:0]  iss_dst,
   output logic [DATA_W-1:0] iss_a,
   output logic [DATA_W-1:0] iss_b
);
   if (ENTRIES < 2) begin : g_bad_depth
      $error("rs_capture_station: ENTRIES must be at least 2");
   end
   if (TAG_W < 1 || TAG_W > DATA_W) begin : g_bad_tag
      $error("rs_capture_station: TAG_W must lie in 1..DATA_W");
   end
   if (OP_W < 1) begin : g_bad_op
      $error("rs_capture_station: OP_W must be positive");
   end

   logic [ENTRIES-1:0] valid_vec;
   logic [ENTRIES-1:0] rdy_vec;
   logic [ENTRIES-1:0] alloc_gnt;
   logic [ENTRIES-1:0] iss_gnt;
   logic               free_any;
   logic               alloc_we;

   logic [RS_NSRC-1:0]             in_rdy;
   logic [RS_NSRC-1:0][DATA_W-1:0] in_val;
   logic [RS_NSRC-1:0]             cap_rdy;
   logic [RS_NSRC-1:0][DATA_W-1:0] cap_val;

   logic [OP_W-1:0]                ent_op  [ENTRIES];
   logic [TAG_W-1:0]               ent_dst [ENTRIES];
   logic [RS_NSRC-1:0][DATA_W-1:0] ent_val [ENTRIES];

   assign in_rdy = {disp_b_rdy, disp_a_rdy};
   assign in_val = {disp_b, disp_a};

   // dispatch-path capture of a result broadcast in the same cycle
   for (genvar s = 0; s < RS_NSRC; s++) begin : g_disp_cap
      rs_src_capture #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_cap (
         .in_rdy   (in_rdy[s]),
         .in_val   (in_val[s]),
         .res_valid(res_valid),
         .res_tag  (res_tag),
         .res_data (res_data),
         .out_rdy  (cap_rdy[s]),
         .out_val  (cap_val[s])
      );
   end

   rs_pick #(.N(ENTRIES)) u_alloc_pick (
      .req(~valid_vec),
      .gnt(alloc_gnt),
      .any(free_any)
   );

   assign disp_full = !free_any;
   assign alloc_we  = disp_valid && free_any;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      rs_entry #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .alloc    (alloc_we && alloc_gnt[e]),
         .alloc_op (disp_op),
         .alloc_dst(disp_dst),
         .alloc_rdy(cap_rdy),
         .alloc_val(cap_val),
         .res_valid(res_valid),
         .res_tag  (res_tag),
         .res_data (res_data),
         .release_i(iss_gnt[e]),
         .valid    (valid_vec[e]),
         .ready    (rdy_vec[e]),
         .op       (ent_op[e]),
         .dst      (ent_dst[e]),
         .val      (ent_val[e])
      );
   end

   rs_pick #(.N(ENTRIES)) u_iss_pick (
      .req(rdy_vec),
      .gnt(iss_gnt),
      .any(iss_valid)
   );

   // one-hot AND-OR issue mux
   always_comb begin
      iss_op  = '0;
      iss_dst = '0;
      iss_a   = '0;
      iss_b   = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         iss_op  |= ent_op[e]     & {OP_W{iss_gnt[e]}};
         iss_dst |= ent_dst[e]    & {TAG_W{iss_gnt[e]}};
         iss_a   |= ent_val[e][0] & {DATA_W{iss_gnt[e]}};
         iss_b   |= ent_val[e][1] & {DATA_W{iss_gnt[e]}};
      end
   end
endmodule

// File: rtl/rs_capture_station_chk.sv
module rs_capture_station_chk #(
   parameter int ENTRIES = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               disp_full,
   input logic               iss_valid,
   input logic [ENTRIES-1:0] valid_vec,
   input logic [ENTRIES-1:0] rdy_vec,
   input logic [ENTRIES-1:0] iss_gnt
);
   assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!disp_full && !iss_valid && valid_vec == '0));

   assert_grant_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_gnt & ~rdy_vec) == '0);

   assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(iss_gnt) && (iss_valid == (iss_gnt != '0)));

   assert_lowest_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((iss_gnt - 1'b1) & rdy_vec) == '0);

   assert_issue_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |=> (valid_vec & $past(iss_gnt)) == '0);

   assert_full_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_full && iss_valid) |=> !disp_full);

   assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_full && !iss_valid) |=> disp_full);
endmodule

bind rs_capture_station rs_capture_station_chk #(.ENTRIES(ENTRIES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .disp_full(disp_full),
   .iss_valid(iss_valid),
   .valid_vec(valid_vec),
   .rdy_vec  (rdy_vec),
   .iss_gnt  (iss_gnt)
);

// File: tb/rs_capture_station_tb.sv
module rs_capture_station_tb;
   localparam int N  = 4;
   localparam int TW = 4;
   localparam int DW = 16;
   localparam int OW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          disp_valid = 1'b0;
   logic [OW-1:0] disp_op = '0;
   logic [TW-1:0] disp_dst = '0;
   logic          disp_a_rdy = 1'b0;
   logic [DW-1:0] disp_a = '0;
   logic          disp_b_rdy = 1'b0;
   logic [DW-1:0] disp_b = '0;
   logic          disp_full;
   logic          res_valid = 1'b0;
   logic [TW-1:0] res_tag = '0;
   logic [DW-1:0] res_data = '0;
   logic          iss_valid;
   logic [OW-1:0] iss_op;
   logic [TW-1:0] iss_dst;
   logic [DW-1:0] iss_a;
   logic [DW-1:0] iss_b;

   always #5 clk = ~clk;

   rs_capture_station #(.ENTRIES(N), .TAG_W(TW), .DATA_W(DW), .OP_W(OW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .disp_valid(disp_valid), .disp_op(disp_op), .disp_dst(disp_dst),
      .disp_a_rdy(disp_a_rdy), .disp_a(disp_a),
      .disp_b_rdy(disp_b_rdy), .disp_b(disp_b),
      .disp_full(disp_full),
      .res_valid(res_valid), .res_tag(res_tag), .res_data(res_data),
      .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
      .iss_a(iss_a), .iss_b(iss_b)
   );

   // behavioural reference: slots of integers
   int m_v[N], m_op[N], m_dst[N], m_ra[N], m_rb[N], m_a[N], m_b[N];
   int vectors = 0;
   int fails   = 0;

   task automatic mis(string req, string what, int act, int exp);
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
   endtask

   task automatic idle_inputs();
      disp_valid = 1'b0;
      res_valid  = 1'b0;
      res_tag    = $urandom;
      res_data   = $urandom;
   endtask

   task automatic cyc(string req);
      int pick, slot, full, tagm;
      int nv[N], nra[N], nrb[N], na[N], nb[N];
      @(negedge clk);
      vectors++;
      pick = -1;
      full = 1;
      slot = -1;
      for (int i = N - 1; i >= 0; i--) begin
         if (m_v[i] != 0 && m_ra[i] != 0 && m_rb[i] != 0) pick = i;
         if (m_v[i] == 0) slot = i;
      end
      if (slot >= 0) full = 0;
      if (int'(disp_full) != full) mis(req, "disp_full", int'(disp_full), full);
      if (int'(iss_valid) != (pick >= 0)) mis(req, "iss_valid", int'(iss_valid), int'(pick >= 0));
      if (pick >= 0 && iss_valid) begin
         if (int'(iss_op)  != m_op[pick])  mis(req, "iss_op",  int'(iss_op),  m_op[pick]);
         if (int'(iss_dst) != m_dst[pick]) mis(req, "iss_dst", int'(iss_dst), m_dst[pick]);
         if (int'(iss_a)   != m_a[pick])   mis(req, "iss_a",   int'(iss_a),   m_a[pick]);
         if (int'(iss_b)   != m_b[pick])   mis(req, "iss_b",   int'(iss_b),   m_b[pick]);
      end
      tagm = int'(res_tag);
      for (int i = 0; i < N; i++) begin
         nv[i] = m_v[i]; nra[i] = m_ra[i]; nrb[i] = m_rb[i]; na[i] = m_a[i]; nb[i] = m_b[i];
         if (i == pick) nv[i] = 0;
         if (res_valid && m_ra[i] == 0 && (m_a[i] % (1 << TW)) == tagm) begin
            nra[i] = 1; na[i] = int'(res_data);
         end
         if (res_valid && m_rb[i] == 0 && (m_b[i] % (1 << TW)) == tagm) begin
            nrb[i] = 1; nb[i] = int'(res_data);
         end
      end
      if (disp_valid && slot >= 0) begin
         nv[slot] = 1;
         m_op[slot] = int'(disp_op);
         m_dst[slot] = int'(disp_dst);
         nra[slot] = int'(disp_a_rdy);
         na[slot]  = int'(disp_a);
         nrb[slot] = int'(disp_b_rdy);
         nb[slot]  = int'(disp_b);
         if (res_valid && !disp_a_rdy && int'(disp_a[TW-1:0]) == tagm) begin
            nra[slot] = 1; na[slot] = int'(res_data);
         end
         if (res_valid && !disp_b_rdy && int'(disp_b[TW-1:0]) == tagm) begin
            nrb[slot] = 1; nb[slot] = int'(res_data);
         end
      end
      @(posedge clk);
      #1;
      for (int i = 0; i < N; i++) begin
         m_v[i] = nv[i]; m_ra[i] = nra[i]; m_rb[i] = nrb[i]; m_a[i] = na[i]; m_b[i] = nb[i];
      end
   endtask

   // drive one dispatch (ra/rb: 1 = value, 0 = pending tag in low bits)
   task automatic disp(int op, int dst, int ra, int va, int rb, int vb);
      disp_valid = 1'b1;
      disp_op    = OW'(op);
      disp_dst   = TW'(dst);
      disp_a_rdy = ra[0];
      disp_a     = DW'(va);
      disp_b_rdy = rb[0];
      disp_b     = DW'(vb);
   endtask

   task automatic bcast(int tag, int data);
      res_valid = 1'b1;
      res_tag   = TW'(tag);
      res_data  = DW'(data);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_v[i] = 0; m_op[i] = 0; m_dst[i] = 0; m_ra[i] = 0; m_rb[i] = 0; m_a[i] = 0; m_b[i] = 0;
      end
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      // R1: empty station after reset
      idle_inputs(); cyc("R1");
      idle_inputs(); cyc("R1");

      // R2: ready-ready dispatch issues next cycle
      idle_inputs(); disp(3, 9, 1, 'h1234, 1, 'hbeef); cyc("R2");
      idle_inputs(); cyc("R2");
      idle_inputs(); cyc("R2");

      // R4: operand B waits on tag 5
      idle_inputs(); disp(6, 2, 1, 'h00aa, 0, 'h7705); cyc("R4");
      idle_inputs(); cyc("R4");
      // R9: foreign tag
      idle_inputs(); bcast(7, 'hdead); cyc("R9");
      // R10: matching tag with valid low
      idle_inputs(); res_valid = 1'b0; res_tag = 4'd5; res_data = 16'hface; cyc("R10");
      idle_inputs(); cyc("R4");
      // R3: matching broadcast captured, issue next cycle
      idle_inputs(); bcast(5, 'h5a5a); cyc("R3");
      idle_inputs(); cyc("R3");

      // R5: dispatch and broadcast in the same cycle, both operands on tag 0xc
      idle_inputs(); disp(1, 4, 0, 'h000c, 0, 'h100c); bcast('hc, 'h0c0c); cyc("R5");
      idle_inputs(); cyc("R5");

      // R8: fill all slots with pending operands, then dispatch while full
      for (int k = 0; k < N; k++) begin
         idle_inputs(); disp(k + 8, k, 0, 'h0100 + (k % 2) + 1, 1, 'h2000 + k); cyc("R8");
      end
      idle_inputs(); cyc("R8");
      idle_inputs(); disp(15, 15, 1, 'hffff, 1, 'heeee); cyc("R8");
      idle_inputs(); cyc("R8");
      // R6: tag 2 wakes slots 1 and 3; lowest first. R7: full drops after issue
      idle_inputs(); bcast(2, 'h0222); cyc("R6");
      idle_inputs(); cyc("R7");
      idle_inputs(); cyc("R7");
      idle_inputs(); disp(14, 13, 1, 'h3333, 1, 'h4444); cyc("R7");
      idle_inputs(); bcast(1, 'h0111); cyc("R6");
      for (int k = 0; k < 4; k++) begin
         idle_inputs(); cyc("R6");
      end

      // random traffic
      for (int k = 0; k < 400; k++) begin
         idle_inputs();
         if ($urandom_range(0, 3) != 0)
            disp($urandom, $urandom, $urandom_range(0, 1), $urandom,
                 $urandom_range(0, 1), $urandom);
         if ($urandom_range(0, 2) != 0) bcast($urandom, $urandom);
         cyc("R3");
      end
      for (int k = 0; k < 16; k++) begin
         idle_inputs(); bcast(k, 'h9000 + k); cyc("R6");
      end
      idle_inputs(); cyc("R6");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule